// File: doc/BRIEF.md
# Addressable LED Serial Waveform Encoder

This block turns a stream of color bytes into the single-wire, return-to-zero waveform that chains of addressable RGB LED controllers expect. A frame is launched by a start command that carries a byte count, three bytes per LED, passed on to the chain in the order they arrive (green, red, blue for each LED). Bytes are then pulled in over a valid/ready handshake into a one-byte holding register.

Every frame opens with a long low period that resets the LED chain. Then each bit takes a fixed slot of ten clock cycles. The line rises at the first cycle of every slot. It falls after two cycles for a zero or after seven cycles for a one, and it is always low in the last cycle of the slot. Bytes go out most significant bit first. If the next byte has not arrived when it is needed, the frame stops with the line low and an underrun flag raised. A frame that completes normally gives a one-cycle done pulse.

Top module: `ledwave_enc`

## Requirements
- R1: After reset `line_o`, `busy_o`, `done_o`, `underrun_o` and `byte_ready_o` are all low.
- R2: A `start_i` pulse in idle with a non-zero `count_i` raises `busy_o` on the next cycle. The line then stays low for exactly RESET_TICKS (320) cycles before the first bit slot begins.
- R3: Every bit slot lasts SLOT_PHASES (10) cycles, and the line is high in the first cycle (phase 0) of every slot.
- R4: A zero bit is high for ZERO_HIGH (2) cycles and low for the rest of the slot. A one bit is high for ONE_HIGH (7) cycles and low for the last 3. The line is low in phase 9 of every slot.
- R5: Each byte is sent most significant bit first, and bytes go out in arrival order. A frame sends exactly `count_i` bytes.
- R6: `byte_ready_o` is high exactly while busy, the holding register is empty, and not all `count_i` bytes have been accepted yet. A byte is taken on a clock edge where `byte_valid_i` and `byte_ready_o` are both high.
- R7: If a byte must start (at the end of the reset period, or after the last slot of a byte while bytes remain) and the holding register is empty, `underrun_o` goes high and `busy_o` drops at that edge. The line stays low. `underrun_o` stays high until the next accepted start.
- R8: After the last slot of the final byte, `done_o` is high for exactly one cycle, `busy_o` drops in that same cycle, and the line stays low.
- R9: A `start_i` while busy is ignored. The running frame continues unchanged.
- R10: A `start_i` with `count_i` equal to 0 is ignored. The block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (one slot phase per cycle) |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a frame (taken only when idle) |
| count_i | input | CNT_W | Number of bytes in the frame |
| byte_i | input | 8 | Color byte |
| byte_valid_i | input | 1 | `byte_i` holds a byte |
| byte_ready_o | output | 1 | Block can take a byte this cycle |
| line_o | output | 1 | Serial data line to the LED chain |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse when a frame completes |
| underrun_o | output | 1 | Frame aborted because no byte was available |

## Verification
A start sampled at edge k makes `busy_o` and `byte_ready_o` true in the cycle after k. The first rise of `line_o` comes RESET_TICKS cycles after that. Within a slot, the line depends only on the registered phase and the current shift bit, so the line level for slot cycle p is visible in cycle p itself. `done_o`, `underrun_o` and the fall of `busy_o` all appear in the cycle after the final phase-9 edge. The bench model advances on the same edges using integers and a byte queue, and compares every output in the middle of each cycle, after inputs have settled and before the next edge.

// File: rtl/ledwave_pkg.sv
package ledwave_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RST  = 2'd1,
    ST_SEND = 2'd2
  } enc_state_t;

  // High time, in cycles, of a slot that carries bit value b
  function automatic int unsigned high_span(input logic b, input int unsigned zero_hi,
                                            input int unsigned one_hi);
    return b ? one_hi : zero_hi;
  endfunction

endpackage

// File: rtl/ledwave_feed.sv
module ledwave_feed #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             arm,
  input  logic [CNT_W-1:0] arm_count,
  input  logic             take,
  input  logic [7:0]       byte_in,
  input  logic             byte_valid,
  output logic             byte_ready,
  output logic             hold_full,
  output logic [7:0]       hold_byte
);

  logic [CNT_W-1:0] fetch_left;
  logic             accept;

  assign byte_ready = run && !hold_full && (fetch_left != '0);
  assign accept     = byte_ready && byte_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_left <= '0;
      hold_full  <= 1'b0;
      hold_byte  <= '0;
    end else if (arm) begin
      fetch_left <= arm_count;
      hold_full  <= 1'b0;
    end else begin
      if (accept) begin
        hold_byte  <= byte_in;
        hold_full  <= 1'b1;
        fetch_left <= fetch_left - 1'b1;
      end else if (take) begin
        hold_full <= 1'b0;
      end
    end
  end

  p_take_needs_byte_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    take |-> hold_full);
  p_ready_only_busy_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> run);

endmodule

// File: rtl/ledwave_slot.sv
module ledwave_slot
  import ledwave_pkg::*;
#(
  parameter int unsigned SLOT_PHASES = 10,
  parameter int unsigned ZERO_HIGH   = 2,
  parameter int unsigned ONE_HIGH    = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       load,
  input  logic [7:0] load_byte,
  output logic       byte_end,
  output logic       line
);

  localparam int unsigned PH_W = (SLOT_PHASES > 1) ? $clog2(SLOT_PHASES) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_PHASES - 1);

  logic [PH_W-1:0] phase;
  logic [2:0]      bit_idx;
  logic [7:0]      shreg;
  logic            slot_end;

  assign slot_end = run && (phase == PH_LAST);
  assign byte_end = slot_end && (bit_idx == 3'd7);
  assign line     = run && (32'(phase) < high_span(shreg[7], ZERO_HIGH, ONE_HIGH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      bit_idx <= '0;
      shreg   <= '0;
    end else if (load) begin
      phase   <= '0;
      bit_idx <= '0;
      shreg   <= load_byte;
    end else if (run) begin
      if (slot_end) begin
        phase   <= '0;
        bit_idx <= bit_idx + 1'b1;
        shreg   <= {shreg[6:0], 1'b0};
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  p_rise_at_phase0_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line) |-> (phase == '0));
  p_low_last_phase_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |-> !line);
  p_high_first_phase_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase == '0) |-> line);

endmodule

// File: rtl/ledwave_enc.sv
module ledwave_enc
  import ledwave_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SLOT_PHASES = 10,
  parameter int unsigned ZERO_HIGH   = 2,
  parameter int unsigned ONE_HIGH    = 7,
  parameter int unsigned RESET_TICKS = 320
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [7:0]       byte_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  output logic             line_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             underrun_o
);

  localparam int unsigned RC_W = $clog2(RESET_TICKS + 1);
  localparam logic [RC_W-1:0] RC_LAST = RC_W'(RESET_TICKS - 1);

  enc_state_t       st;
  logic [RC_W-1:0]  rcnt;
  logic [CNT_W-1:0] send_left;
  logic             done_q, under_q;

  logic       arm, rst_last, byte_end, need_byte, load, starve, finish, run;
  logic       hold_full;
  logic [7:0] hold_byte;

  assign arm       = (st == ST_IDLE) && start_i && (count_i != '0);
  assign rst_last  = (st == ST_RST) && (rcnt == RC_LAST);
  assign need_byte = rst_last || (byte_end && (send_left != '0));
  assign load      = need_byte && hold_full;
  assign starve    = need_byte && !hold_full;
  assign finish    = byte_end && (send_left == '0);
  assign run       = (st == ST_SEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      rcnt      <= '0;
      send_left <= '0;
      done_q    <= 1'b0;
      under_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) send_left <= send_left - 1'b1;
      unique case (st)
        ST_IDLE: if (arm) begin
          st        <= ST_RST;
          rcnt      <= '0;
          send_left <= count_i;
          under_q   <= 1'b0;
        end
        ST_RST: begin
          rcnt <= rcnt + 1'b1;
          if (load) st <= ST_SEND;
          else if (starve) begin
            st      <= ST_IDLE;
            under_q <= 1'b1;
          end
        end
        ST_SEND: begin
          if (finish) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end else if (starve) begin
            st      <= ST_IDLE;
            under_q <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  ledwave_feed #(.CNT_W(CNT_W)) u_feed (
    .clk(clk), .rst_n(rst_n), .run(st != ST_IDLE), .arm(arm), .arm_count(count_i),
    .take(load), .byte_in(byte_i), .byte_valid(byte_valid_i),
    .byte_ready(byte_ready_o), .hold_full(hold_full), .hold_byte(hold_byte)
  );

  ledwave_slot #(.SLOT_PHASES(SLOT_PHASES), .ZERO_HIGH(ZERO_HIGH), .ONE_HIGH(ONE_HIGH)) u_slot (
    .clk(clk), .rst_n(rst_n), .run(run), .load(load), .load_byte(hold_byte),
    .byte_end(byte_end), .line(line_o)
  );

  assign busy_o     = (st != ST_IDLE);
  assign done_o     = done_q;
  assign underrun_o = under_q;

  p_idle_line_low_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !line_o);
  p_done_single_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_ends_busy_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
  p_under_stops_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun_o) |-> !busy_o);
  p_reset_line_low_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RST) |-> !line_o);
  p_busy_start_ignored_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !done_o && !starve && !finish) |=> busy_o);

endmodule

// File: tb/tb_ledwave_enc.sv
module tb_ledwave_enc;

  localparam int CNT_W = 16;
  localparam int SLOT  = 10;
  localparam int ZH    = 2;
  localparam int OH    = 7;
  localparam int RSTT  = 320;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [CNT_W-1:0] count_i = '0;
  logic [7:0]       byte_i = '0;
  logic             byte_valid_i = 1'b0;
  logic             byte_ready_o, line_o, busy_o, done_o, underrun_o;

  always #5 clk = ~clk;

  ledwave_enc #(.CNT_W(CNT_W), .SLOT_PHASES(SLOT), .ZERO_HIGH(ZH), .ONE_HIGH(OH),
                .RESET_TICKS(RSTT)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i), .byte_i(byte_i),
    .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o), .line_o(line_o),
    .busy_o(busy_o), .done_o(done_o), .underrun_o(underrun_o)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: mode 0 idle, 1 reset gap, 2 sending
  int       m_mode = 0, m_tick = 0, m_send = 0, m_fetch = 0;
  bit       m_hold_v = 0, m_done = 0, m_under = 0;
  bit [7:0] m_hold = 0, m_cur = 0;
  bit [7:0] feed_q[$];

  function automatic bit exp_ready();
    return m_mode != 0 && !m_hold_v && m_fetch > 0;
  endfunction

  function automatic bit exp_line();
    int b;
    if (m_mode != 2) return 1'b0;
    b = m_cur[7 - m_tick / SLOT];
    return (m_tick % SLOT) < (b ? OH : ZH);
  endfunction

  always @(posedge clk) begin
    bit acc;
    if (!rst_n) begin
      m_mode = 0; m_hold_v = 0; m_done = 0; m_under = 0; m_fetch = 0; m_send = 0;
    end else begin
      acc = exp_ready() && byte_valid_i;
      m_done = 0;
      case (m_mode)
        0: if (start_i && count_i != 0) begin
             m_mode = 1; m_tick = 0; m_send = count_i; m_fetch = count_i;
             m_hold_v = 0; m_under = 0;
           end
        1: if (m_tick == RSTT - 1) begin
             if (m_hold_v) begin
               m_cur = m_hold; m_hold_v = 0; m_send--; m_mode = 2; m_tick = 0;
             end else begin
               m_under = 1; m_mode = 0;
             end
           end else m_tick++;
        default: if (m_tick == 8 * SLOT - 1) begin
             if (m_send == 0) begin
               m_done = 1; m_mode = 0;
             end else if (m_hold_v) begin
               m_cur = m_hold; m_hold_v = 0; m_send--; m_tick = 0;
             end else begin
               m_under = 1; m_mode = 0;
             end
           end else m_tick++;
      endcase
      if (acc) begin
        m_hold = byte_i; m_hold_v = 1; m_fetch--;
        void'(feed_q.pop_front());
      end
    end
  end

  // Per-cycle comparison in the middle of the low clock phase
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      check(line_o == exp_line(), "R3/R4/R5 line", line_o, exp_line());
      check(byte_ready_o == exp_ready(), "R6 ready", byte_ready_o, exp_ready());
      check(busy_o == (m_mode != 0), "R2/R9/R10 busy", busy_o, m_mode != 0);
      check(done_o == m_done, "R8 done", done_o, m_done);
      check(underrun_o == m_under, "R7 underrun", underrun_o, m_under);
    end
  end

  // Byte source: offers the queue head whenever the queue is not empty
  initial forever begin
    @(negedge clk);
    byte_valid_i = feed_q.size() > 0;
    byte_i = (feed_q.size() > 0) ? feed_q[0] : 8'h00;
  end

  task automatic pulse_start(input int n);
    @(negedge clk); start_i = 1'b1; count_i = CNT_W'(n);
    @(negedge clk); start_i = 1'b0;
  endtask

  // Starts a frame, measures the reset gap, waits for its end
  task automatic run_frame(input int n, input bit expect_gap);
    int gap;
    pulse_start(n);
    #2;
    check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    gap = 0;
    while (!line_o && busy_o) begin @(negedge clk); #2; gap++; end
    if (expect_gap) check(gap == RSTT, "R2 reset gap", gap, RSTT);
    while (busy_o) begin @(negedge clk); #2; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check(!line_o && !busy_o && !done_o && !underrun_o && !byte_ready_o,
          "R1 reset outputs", {line_o, busy_o, done_o, underrun_o, byte_ready_o}, 0);
    @(negedge clk); rst_n = 1'b1;

    // One LED, mixed bits (R5 order and MSB first)
    feed_q = '{8'hA5, 8'h3C, 8'hFF};
    run_frame(3, 1);
    check(!underrun_o, "R8 clean finish", underrun_o, 0);

    // Two LEDs with edge patterns, start pulses while busy (R9)
    feed_q = '{8'h00, 8'h80, 8'h01, 8'hFF, 8'h55, 8'hAA};
    fork
      run_frame(6, 1);
      begin
        repeat (100) @(negedge clk);
        start_i = 1'b1; count_i = 16'd3;
        @(negedge clk); start_i = 1'b0;
        repeat (400) @(negedge clk);
        start_i = 1'b1; count_i = 16'd9;
        @(negedge clk); start_i = 1'b0;
      end
    join
    repeat (3) @(negedge clk);
    #2;
    check(!busy_o, "R9 no restart from busy start", busy_o, 0);

    // Count zero ignored (R10)
    pulse_start(0);
    repeat (2) @(negedge clk);
    #2;
    check(!busy_o && !byte_ready_o, "R10 zero count ignored", busy_o, 0);

    // Underrun mid-frame (R7)
    feed_q = '{8'hC3, 8'h18};
    run_frame(6, 1);
    check(underrun_o == 1'b1, "R7 underrun mid-frame", underrun_o, 1);
    check(!line_o, "R7 line low after underrun", line_o, 0);

    // Underrun at end of the reset gap (R7)
    feed_q.delete();
    run_frame(3, 0);
    check(underrun_o == 1'b1, "R7 underrun at gap end", underrun_o, 1);

    // New start clears underrun
    feed_q = '{8'h12, 8'h34, 8'h56};
    run_frame(3, 1);
    check(!underrun_o, "R7 underrun cleared", underrun_o, 0);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule